// File: doc/BRIEF.md
# S/PDIF Channel-Status Flag and Block-Marker Extractor

This block sits behind an S/PDIF subframe decoder. For each subframe the decoder offers one strobe, a left/right indication, a block-start indication (the subframe carried the B preamble), and that subframe's channel-status and user bits. The block numbers the frames of each 192-frame block. From the left channel it gathers the first channel-status byte and turns it into two steady flags: pre-emphasis and non-audio. It also drives a block marker that stays high for the first 32 frames of a block.

The channel-status and user bits of both channels also leave the block as two serial streams, left and right interleaved. They run a fixed number of subframes behind the input. The default lag is four subframes, which is two frames or 128 bit-clock periods at 64 bit clocks per frame. Byte-0 bit 0 chooses how the emphasis field is read: professional when high, consumer when low. No CRC is computed.

Top module: `spdif_cs_flags`

## Requirements
- R1: While and after reset, emph_flag, nonaudio_flag, blk_mark, cs_ser and usr_ser are all low.
- R2: With byte-0 bit 0 = 1 (professional), emph_flag is set exactly when bit 2 = 1, bit 3 = 1 and bit 4 = 0.
- R3: With byte-0 bit 0 = 0 (consumer), emph_flag is set exactly when bit 3 = 1, bit 4 = 0 and bit 5 = 0. Bit 2 has no influence.
- R4: nonaudio_flag equals byte-0 bit 1 (0 = PCM audio, 1 = other data).
- R5: Byte 0 is built only from left subframes (sub_left = 1). Bit n comes from frame n, where frame 0 is the left subframe that carries blk_start. Right-channel status bits never affect the flags.
- R6: The flags change only on the edge that takes the left subframe of frame 7, when all 8 bits are in. Until then they keep their previous values.
- R7: blk_mark rises on the left subframe with blk_start. It stays high through frame 31 and falls when the left subframe of frame 32 is taken.
- R8: A blk_start inside a block restarts frame numbering at 0. The marker then lasts 32 frames from that new start.
- R9: On each strobe, cs_ser and usr_ser take the bits of the subframe LAT_SUB (default 4) strobes earlier, in arrival order and including both channels. They are 0 until that many strobes have occurred.
- R10: Cycles with sub_valid = 0 leave every output unchanged, whatever the other inputs do.
- R11: After frame 191, numbering wraps to 0 without blk_start. This wrap neither raises blk_mark nor starts a new byte-0 collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_valid | input | 1 | One-cycle strobe per decoded subframe |
| sub_left | input | 1 | Subframe is the left channel |
| blk_start | input | 1 | Subframe carried the block-start preamble (honoured on left subframes only) |
| cs_in | input | 1 | Channel-status bit of the subframe |
| usr_in | input | 1 | User bit of the subframe |
| emph_flag | output | 1 | 50/15 us pre-emphasis indicated |
| nonaudio_flag | output | 1 | Payload is not linear PCM |
| blk_mark | output | 1 | High for frames 0 to 31 of a block |
| cs_ser | output | 1 | Delayed serial channel-status stream |
| usr_ser | output | 1 | Delayed serial user-bit stream |

## Verification
The assertions assume that every strobe lasts one cycle and that left and right subframes alternate. They also assume that blk_start comes only with a left subframe, so that a marker edge or a flag change can always be traced to a left strobe in the previous cycle. The bench sends subframes only in left-then-right pairs, with an idle cycle after each strobe. It raises blk_start only on the left half of a frame, and toggles the data inputs freely only while sub_valid is low.

// File: rtl/spdif_cs_flags.sv
module spdif_cs_flags #(
  parameter int FRAMES_PER_BLOCK = 192,
  parameter int MARK_FRAMES      = 32,
  parameter int BYTE_BITS        = 8,
  parameter int LAT_SUB          = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_valid,
  input  logic sub_left,
  input  logic blk_start,
  input  logic cs_in,
  input  logic usr_in,
  output logic emph_flag,
  output logic nonaudio_flag,
  output logic blk_mark,
  output logic cs_ser,
  output logic usr_ser
);
  localparam int FW   = $clog2(FRAMES_PER_BLOCK);
  localparam int KEEP = 6;

  logic           left_stb, b_stb, take, last;
  logic [FW-1:0]  fidx, fidx_nxt;
  logic           coll;
  logic [KEEP-1:0] byte0;
  logic [LAT_SUB-1:0] cs_pipe, usr_pipe;
  logic           emph_nxt;

  assign left_stb = sub_valid & sub_left;
  assign b_stb    = left_stb & blk_start;
  assign fidx_nxt = b_stb ? '0 :
                    (fidx == FW'(FRAMES_PER_BLOCK - 1)) ? '0 : fidx + FW'(1);
  assign take     = left_stb & (b_stb | coll);
  assign last     = take & (fidx_nxt == FW'(BYTE_BITS - 1));
  assign emph_nxt = byte0[0] ? (byte0[4:2] == 3'b011) : (byte0[5:3] == 3'b001);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fidx          <= '0;
      coll          <= 1'b0;
      byte0         <= '0;
      blk_mark      <= 1'b0;
      emph_flag     <= 1'b0;
      nonaudio_flag <= 1'b0;
      cs_pipe       <= '0;
      usr_pipe      <= '0;
      cs_ser        <= 1'b0;
      usr_ser       <= 1'b0;
    end else begin
      if (left_stb) begin
        fidx <= fidx_nxt;
        if (b_stb)
          blk_mark <= 1'b1;
        else if (fidx_nxt == FW'(MARK_FRAMES))
          blk_mark <= 1'b0;
      end
      if (take) begin
        if (fidx_nxt < FW'(KEEP))
          byte0[fidx_nxt[2:0]] <= cs_in;
        coll <= !last;
        if (last) begin
          emph_flag     <= emph_nxt;
          nonaudio_flag <= byte0[1];
        end
      end
      if (sub_valid) begin
        cs_pipe  <= {cs_pipe[LAT_SUB-2:0], cs_in};
        usr_pipe <= {usr_pipe[LAT_SUB-2:0], usr_in};
        cs_ser   <= cs_pipe[LAT_SUB-1];
        usr_ser  <= usr_pipe[LAT_SUB-1];
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !$past(rst_n) |-> !emph_flag && !nonaudio_flag && !blk_mark && !cs_ser && !usr_ser);

  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sub_valid && sub_left) |-> $stable(emph_flag) && $stable(nonaudio_flag));

  a_r7_mark_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_mark) |-> $past(sub_valid && sub_left && blk_start));

  a_r7_mark_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk_mark) |-> $past(sub_valid && sub_left && !blk_start));

  a_r10_serial_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sub_valid) |-> $stable(cs_ser) && $stable(usr_ser) && $stable(blk_mark));

  a_r11_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    fidx < FW'(FRAMES_PER_BLOCK));
endmodule

// File: tb/test_spdif_cs_flags.sv
module test_spdif_cs_flags;
  logic clk = 1'b0;
  logic rst_n, sub_valid, sub_left, blk_start, cs_in, usr_in;
  logic emph_flag, nonaudio_flag, blk_mark, cs_ser, usr_ser;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  spdif_cs_flags i_spdif_cs_flags (
    .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_left(sub_left),
    .blk_start(blk_start), .cs_in(cs_in), .usr_in(usr_in),
    .emph_flag(emph_flag), .nonaudio_flag(nonaudio_flag), .blk_mark(blk_mark),
    .cs_ser(cs_ser), .usr_ser(usr_ser));

  // {byte 0, expected emphasis, expected non-audio}
  localparam logic [9:0] VEC [12] = '{
    {8'h00, 2'b00}, {8'h08, 2'b10}, {8'h0A, 2'b11}, {8'h18, 2'b00},
    {8'h0D, 2'b10}, {8'h0F, 2'b11}, {8'h1D, 2'b00}, {8'h09, 2'b00},
    {8'h03, 2'b01}, {8'h0C, 2'b10}, {8'h28, 2'b00}, {8'h8D, 2'b10}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sub_valid = 1'b0; sub_left = 1'b0; blk_start = 1'b0;
    cs_in = 1'b0; usr_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {3'b0, emph_flag, nonaudio_flag, blk_mark, cs_ser, usr_ser}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", {3'b0, emph_flag, nonaudio_flag, blk_mark, cs_ser, usr_ser}, 8'h00);
  endtask

  task automatic sub(input logic l, input logic b, input logic c, input logic u);
    @(negedge clk);
    sub_valid = 1'b1; sub_left = l; blk_start = b; cs_in = c; usr_in = u;
    @(negedge clk);
    sub_valid = 1'b0; blk_start = 1'b0;
  endtask

  task automatic frame(input logic b, input logic cl, input logic cr);
    sub(1'b1, b, cl, 1'b0);
    sub(1'b0, 1'b0, cr, 1'b1);
  endtask

  initial begin
    logic [1:0] prev;
    logic [7:0] byte_v;
    logic       cs_h [64];
    logic       u_h  [64];
    logic [4:0] snap;
    prev = 2'b00;
    do_reset();

    // R2 R3 R4 R5 R6: table of byte-0 patterns, right channel carries the inverse
    for (int v = 0; v < 12; v++) begin
      byte_v = VEC[v][9:2];
      for (int f = 0; f < 8; f++) begin
        frame(f == 0, byte_v[f], ~byte_v[f]);
        if (f == 6) chk("R6 flags held before frame 7", {6'b0, emph_flag, nonaudio_flag}, {6'b0, prev});
      end
      chk(byte_v[0] ? "R2 R4 R5 professional decode" : "R3 R4 R5 consumer decode",
          {6'b0, emph_flag, nonaudio_flag}, {6'b0, VEC[v][1:0]});
      prev = VEC[v][1:0];
    end

    // R7: marker length over a full block, all status bits zero
    for (int f = 0; f < 192; f++) begin
      frame(f == 0, 1'b0, 1'b1);
      if (f == 0)  chk("R7 marker rises on block start", {7'b0, blk_mark}, 8'h01);
      if (f == 31) chk("R7 marker high at frame 31", {7'b0, blk_mark}, 8'h01);
      if (f == 32) chk("R7 marker low at frame 32", {7'b0, blk_mark}, 8'h00);
      if (f == 7)  chk("R6 flags from zero byte", {6'b0, emph_flag, nonaudio_flag}, 8'h00);
    end
    // R11: wrap without block start, left bits all ones
    for (int f = 0; f < 12; f++) begin
      frame(1'b0, 1'b1, 1'b1);
      if (f == 0) chk("R11 wrap leaves marker low", {7'b0, blk_mark}, 8'h00);
      if (f == 7) chk("R11 wrap starts no collection", {6'b0, emph_flag, nonaudio_flag}, 8'h00);
    end

    // R8: new block start in mid-block restarts numbering
    for (int f = 0; f < 50; f++) frame(f == 0, 1'b0, 1'b0);
    chk("R8 marker low mid-block", {7'b0, blk_mark}, 8'h00);
    for (int f = 0; f < 33; f++) begin
      frame(f == 0, 1'b0, 1'b0);
      if (f == 0)  chk("R8 marker rises on early start", {7'b0, blk_mark}, 8'h01);
      if (f == 31) chk("R8 marker high 31 frames after restart", {7'b0, blk_mark}, 8'h01);
      if (f == 32) chk("R8 marker low 32 frames after restart", {7'b0, blk_mark}, 8'h00);
    end

    // R9: serial streams lag by four subframes
    do_reset();
    for (int k = 0; k < 40; k++) begin
      cs_h[k] = ((k * 7 + 3) % 5) < 2;
      u_h[k]  = (k % 3) == 0;
      sub(k % 2 == 0, 1'b0, cs_h[k], u_h[k]);
      chk("R9 serial lag", {6'b0, cs_ser, usr_ser},
          (k >= 4) ? {6'b0, cs_h[k-4], u_h[k-4]} : 8'h00);
    end

    // R10: inputs wiggling without a strobe change nothing
    frame(1'b1, 1'b1, 1'b1);
    snap = {emph_flag, nonaudio_flag, blk_mark, cs_ser, usr_ser};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sub_left = i[0]; blk_start = i[1]; cs_in = ~i[0]; usr_in = i[2];
    end
    @(negedge clk);
    chk("R10 idle inputs ignored", {3'b0, emph_flag, nonaudio_flag, blk_mark, cs_ser, usr_ser}, {3'b0, snap});

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule